// File: doc/BRIEF.md
# Quadrature Position Counter with Wrap-Around Limit

This block turns a pair of quadrature encoder signals into a position count. Both encoder lines are asynchronous to the block clock, so they first pass through a synchronizer. A phase tracker then compares each synchronized sample with the previous one and decides whether the shaft moved one step forward, one step back, or not at all. Every edge of either line is one step, which is x4 decoding.

The count runs between zero and a limit value supplied by the host. A step up from the limit lands on zero, and a step down from zero lands on the limit. Program the limit before enabling the counter.

A small direction state machine remembers which way the last counted step went. A reversal raises a sticky up flag or a sticky down flag, depending on the new direction. Each flag stays set until its own clear strobe. A single interrupt line reports either flag while the interrupt enable bit is set.

Phase tracker states are named by the synchronized pair {A,B}:
- `PH_00`, `PH_10`, `PH_11`, `PH_01`.
- Moving forward through that list, wrapping back to the start, is an up step.
- Moving backward through it is a down step.
- Staying in place gives no step.
- Jumping to the opposite state (both bits changed) is invalid and gives no step.

Direction machine states:
- `DIR_UP` and `DIR_DN`.
- `DIR_UP -> DIR_DN` on a counted down step. This sets the down flag.
- `DIR_DN -> DIR_UP` on a counted up step. This sets the up flag.

Top module: `quad_pos_counter`

## Requirements
- R1: With `{A,B}` as a 2-bit value, the synchronized sequence 00→10→11→01→00 counts up by one per transition (A leads B), and the reverse sequence counts down by one per transition.
- R2: An up step while the count is at or above `limit_i` sets the count to 0.
- R3: A down step while the count is 0 sets the count to `limit_i`.
- R4: When both inputs change between two consecutive synchronized samples, the count and both flags are left unchanged.
- R5: Each input passes through a two-flop synchronizer. An input change set up before clock edge k changes the count just after edge k+2.
- R6: While `en_i` is low, steps change neither the count nor the flags. The phase tracker keeps following the inputs, so raising `en_i` produces no spurious step.
- R7: The direction memory resets to up. A counted down step taken while the direction is up sets `dn_flag_o`, and a counted up step taken while the direction is down sets `up_flag_o`. A step in the same direction as the last one sets no flag.
- R8: Each flag stays set until a cycle in which its clear strobe is 1. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` equals `irq_en_i AND (up_flag_o OR dn_flag_o)`.
- R10: After reset, the count is 0, both flags are 0, and the phase tracker sits in `PH_00`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; both encoder inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Encoder line A, asynchronous |
| enc_b_i | input | 1 | Encoder line B, asynchronous |
| limit_i | input | CNT_W | Wrap limit (auto-reload value) |
| en_i | input | 1 | Counting enable |
| clr_up_i | input | 1 | Write-one strobe that clears the up flag |
| clr_dn_i | input | 1 | Write-one strobe that clears the down flag |
| irq_en_i | input | 1 | Direction-change interrupt enable |
| count_o | output | CNT_W | Current position count |
| up_flag_o | output | 1 | Sticky flag: direction changed to up |
| dn_flag_o | output | 1 | Sticky flag: direction changed to down |
| irq_o | output | 1 | Direction-change interrupt |

## Verification
The wrap assertions assume that `limit_i` does not change while counting is enabled. The stimulus writes the limit once during reset and never touches it again.

The step assertions assume that each encoder line toggles no faster than one quarter of the clock rate. The stimulus therefore spaces consecutive edges at least three clocks apart, so each line's period is at least twelve clocks.

Deliberate invalid moves are made by flipping both lines in the same cycle. This is the only way the stimulus breaks the one-line-at-a-time pattern.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Step decision produced by the phase tracker
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

    // Phase states, encoded directly as the synchronized pair {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_10 = 2'b10,
        PH_11 = 2'b11,
        PH_01 = 2'b01
    } phase_e;

    // Last counted direction
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[g] <= '0;
                    else        pipe_q[g] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe_q[g] <= '0;
                    else        pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[LAST];

    // R5: the output is the input delayed by exactly two edges (default depth)
    a_r5_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2 && $past(rst_n)) |=> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_i,
    output step_e      step_o
);
    phase_e phase_q;
    phase_e phase_d;
    phase_e fwd;
    phase_e bwd;

    assign phase_d = phase_e'(ab_i);

    // State register: follows the synchronized pair every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_00;
        else        phase_q <= phase_d;
    end

    // Output logic: neighbours of the current phase decide the step
    always_comb begin
        unique case (phase_q)
            PH_00: begin fwd = PH_10; bwd = PH_01; end
            PH_10: begin fwd = PH_11; bwd = PH_00; end
            PH_11: begin fwd = PH_01; bwd = PH_10; end
            PH_01: begin fwd = PH_00; bwd = PH_11; end
        endcase
        if (phase_d == fwd)      step_o = STEP_UP;
        else if (phase_d == bwd) step_o = STEP_DN;
        else                     step_o = STEP_NONE;
    end

    // R4: a jump to the opposite phase never yields a step
    a_r4_opposite_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_i == ~phase_q) |-> (step_o == STEP_NONE));

    // R6: the tracker keeps following inputs regardless of enable
    a_r6_phase_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase_q == phase_e'($past(ab_i))));

    // R1: a one-bit change always yields a step
    a_r1_single_edge_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ab_i ^ phase_q) == 1) |-> (step_o != STEP_NONE));

endmodule

// File: rtl/qenc_wrapcnt.sv
module qenc_wrapcnt
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  step_e            step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (en_i) begin
            unique case (step_i)
                STEP_UP:   cnt_d = (cnt_q >= limit_i) ? ZERO : cnt_q + ONE;
                STEP_DN:   cnt_d = (cnt_q == ZERO) ? limit_i : cnt_q - ONE;
                default:   cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_i == STEP_UP && cnt_q >= limit_i) |=> (count_o == ZERO));

    a_r3_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_i == STEP_DN && cnt_q == ZERO) |=> (count_o == $past(limit_i)));

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || step_i == STEP_NONE) |=> $stable(count_o));

endmodule

// File: rtl/qenc_dirflags.sv
module qenc_dirflags
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  step_e step_i,
    input  logic  clr_up_i,
    input  logic  clr_dn_i,
    output logic  up_flag_o,
    output logic  dn_flag_o
);
    dir_e dir_q;
    dir_e dir_d;
    logic set_up;
    logic set_dn;
    logic up_q;
    logic dn_q;

    // Next-state and event outputs
    always_comb begin
        dir_d  = dir_q;
        set_up = 1'b0;
        set_dn = 1'b0;
        if (en_i) begin
            unique case (dir_q)
                DIR_UP: if (step_i == STEP_DN) begin dir_d = DIR_DN; set_dn = 1'b1; end
                DIR_DN: if (step_i == STEP_UP) begin dir_d = DIR_UP; set_up = 1'b1; end
            endcase
        end
    end

    // State and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            up_q  <= 1'b0;
            dn_q  <= 1'b0;
        end else begin
            dir_q <= dir_d;
            up_q  <= set_up | (up_q & ~clr_up_i);
            dn_q  <= set_dn | (dn_q & ~clr_dn_i);
        end
    end

    assign up_flag_o = up_q;
    assign dn_flag_o = dn_q;

    a_r7_dn_on_reversal: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_i == STEP_DN && dir_q == DIR_UP) |=> dn_flag_o);

    a_r7_up_on_reversal: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_i == STEP_UP && dir_q == DIR_DN) |=> up_flag_o);

    a_r8_up_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (up_flag_o && !clr_up_i) |=> up_flag_o);

    a_r8_dn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_flag_o && !clr_dn_i) |=> dn_flag_o);

    a_r6_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !up_flag_o && !dn_flag_o) |=> (!up_flag_o && !dn_flag_o));

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             en_i,
    input  logic             clr_up_i,
    input  logic             clr_dn_i,
    input  logic             irq_en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             up_flag_o,
    output logic             dn_flag_o,
    output logic             irq_o
);
    logic [1:0] ab_sync;
    step_e      step;

    qenc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({enc_a_i, enc_b_i}),
        .q_o   (ab_sync)
    );

    qenc_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ab_i   (ab_sync),
        .step_o (step)
    );

    qenc_wrapcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .step_i  (step),
        .limit_i (limit_i),
        .count_o (count_o)
    );

    qenc_dirflags u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .step_i    (step),
        .clr_up_i  (clr_up_i),
        .clr_dn_i  (clr_dn_i),
        .up_flag_o (up_flag_o),
        .dn_flag_o (dn_flag_o)
    );

    assign irq_o = irq_en_i & (up_flag_o | dn_flag_o);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i);

    a_r9_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i && (up_flag_o || dn_flag_o)) |-> irq_o);

    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (count_o == '0 && !up_flag_o && !dn_flag_o));

endmodule

// File: tb/quad_pos_counter_tb.sv
`timescale 1ns/100ps
module quad_pos_counter_tb;
    localparam int W = 16;
    localparam logic [W-1:0] LIM = 16'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b0, b = 1'b0;
    logic [W-1:0] limit = LIM;
    logic en = 1'b0, clr_up = 1'b0, clr_dn = 1'b0, ie = 1'b0;
    logic [W-1:0] count;
    logic up_f, dn_f, irq;

    int checks = 0;
    int fails = 0;
    string cur_tag = "R10";
    int pidx = 0;

    always #2 clk = ~clk;

    quad_pos_counter #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a_i(a), .enc_b_i(b), .limit_i(limit),
        .en_i(en), .clr_up_i(clr_up), .clr_dn_i(clr_dn), .irq_en_i(ie),
        .count_o(count), .up_flag_o(up_f), .dn_flag_o(dn_f), .irq_o(irq)
    );

    // Behavioural reference model
    int m_s1, m_s2, m_ph, m_cnt, m_dir;
    bit m_up, m_dn;

    function automatic int pos_of(int ab);
        case (ab)
            0: return 0;
            2: return 1;
            3: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int ab_of(int p);
        case (p & 3)
            0: return 0;
            1: return 2;
            2: return 3;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_ph = 0; m_cnt = 0; m_dir = 0; m_up = 0; m_dn = 0;
        end else begin
            int delta;
            bit su, sd;
            delta = (pos_of(m_s2) - pos_of(m_ph) + 4) % 4;
            su = 0; sd = 0;
            if (en && delta == 1) begin
                m_cnt = (m_cnt >= int'(limit)) ? 0 : m_cnt + 1;
                if (m_dir == 1) su = 1;
                m_dir = 0;
            end else if (en && delta == 3) begin
                m_cnt = (m_cnt == 0) ? int'(limit) : m_cnt - 1;
                if (m_dir == 0) sd = 1;
                m_dir = 1;
            end
            m_up = su || (m_up && !clr_up);
            m_dn = sd || (m_dn && !clr_dn);
            m_ph = m_s2;
            m_s2 = m_s1;
            m_s1 = {30'd0, a, b};
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare on every clock, shortly after the edge
    always begin
        @(posedge clk);
        #1;
        chk(cur_tag, "count", int'(count), m_cnt);
        chk(cur_tag, "up_flag", int'(up_f), int'(m_up));
        chk(cur_tag, "dn_flag", int'(dn_f), int'(m_dn));
        chk("R9", "irq", int'(irq), int'(ie && (m_up || m_dn)));
    end

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic move(int dir, int n);
        for (int i = 0; i < n; i++) begin
            pidx = (pidx + dir + 4) % 4;
            {a, b} = 2'(ab_of(pidx));
            wait_clks(3);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_clks(4);
        chk("R10", "reset count", int'(count), 0);
        chk("R10", "reset flags", int'(up_f | dn_f), 0);
        rst_n = 1'b1;
        en = 1'b1;
        wait_clks(2);

        // R5 latency: count must not move until the third edge after the change
        cur_tag = "R5";
        pidx = 1; {a, b} = 2'b10;
        wait_clks(2);
        chk("R5", "count before sync", int'(count), 0);
        wait_clks(1);
        chk("R5", "count after sync", int'(count), 1);

        cur_tag = "R2";
        move(1, 7);
        chk("R2", "up wrap", int'(count), 2);
        chk("R7", "no flag same dir", int'(up_f | dn_f), 0);

        cur_tag = "R3";
        move(-1, 10);
        chk("R3", "down wrap", int'(count), 4);
        chk("R7", "dn flag on reversal", int'(dn_f), 1);
        chk("R7", "up flag stays clear", int'(up_f), 0);

        cur_tag = "R8";
        wait_clks(3);
        chk("R8", "dn flag sticky", int'(dn_f), 1);
        clr_dn = 1'b1; wait_clks(1); clr_dn = 1'b0;
        wait_clks(1);
        chk("R8", "dn flag cleared", int'(dn_f), 0);

        cur_tag = "R7";
        move(1, 1);
        chk("R7", "up flag on reversal", int'(up_f), 1);
        chk("R1", "count after up", int'(count), 5);

        cur_tag = "R9";
        chk("R9", "irq masked", int'(irq), 0);
        ie = 1'b1; wait_clks(1);
        chk("R9", "irq raised", int'(irq), 1);

        cur_tag = "R4";
        pidx = (pidx + 2) % 4;
        {a, b} = ~{a, b};
        wait_clks(4);
        chk("R4", "invalid keeps count", int'(count), 5);

        // Set and clear in the same cycle: hold clear while reversing
        cur_tag = "R8";
        clr_dn = 1'b1;
        move(-1, 1);
        clr_dn = 1'b0;
        wait_clks(1);
        chk("R8", "set beats clear", int'(dn_f), 1);
        clr_up = 1'b1; clr_dn = 1'b1; wait_clks(1); clr_up = 1'b0; clr_dn = 1'b0;
        wait_clks(1);
        chk("R9", "irq low after clear", int'(irq), 0);

        cur_tag = "R6";
        en = 1'b0;
        move(1, 3);
        chk("R6", "count held", int'(count), 4);
        chk("R6", "no flags", int'(up_f | dn_f), 0);
        en = 1'b1;
        wait_clks(4);
        chk("R6", "no step on enable", int'(count), 4);
        move(1, 1);
        chk("R2", "count after enable", int'(count), 5);
        move(1, 1);
        chk("R2", "wrap again", int'(count), 0);
        chk("R7", "up flag after disabled reversal", int'(up_f), 1);

        cur_tag = "R1";
        move(-1, 6);
        move(1, 9);
        wait_clks(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule